// File: doc/BRIEF.md
# Flash Row Program Latch Controller

This block controls a byte-wide flash array that is written one row at a time. Software does not write flash cells directly. It first turns on latch access in an 8-bit control register. It then writes up to sixteen bytes, which are held in a bank of staging latches indexed by the low four address bits. Finally it sets the program bit. The block stays busy for a fixed number of clock cycles, then writes every staged byte into one row of the array in a single step. At the end of that cycle the block clears its own control bits and empties the latches.

The target row is taken from the upper address bits of the last staged write, so software should keep a sequence within one row. Latch positions that were not written in a sequence leave their array bytes untouched. A third control bit steers accesses to a small two-byte option store instead of the main array.

The bus is a simple strobed interface. The highest address bit selects the control register; all other addresses fall in the flash area. Read data is registered and appears in the cycle after the read strobe. The array is behavioural storage that comes out of reset erased, with every byte reading 0xFF.

Top module: `flash_wlatch_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, `prog_busy` is low, and every array byte and option byte reads 0xFF.
- R2: Control register layout: bit 0 is the program bit, bit 1 is latch access, and bit 2 is option-area select. Bits 7..3 always read 0, whatever was written to them.
- R3: While latch access is off, writes to the flash area have no effect, and reads of the flash area return the stored array contents.
- R4: While latch access is on and programming is idle, a flash-area write stages its byte in latch `addr[3:0]`. The array byte does not change until a program cycle commits it.
- R5: A register write with bits 1 and 0 both set starts a program cycle. `prog_busy` (the program bit) then stays high for exactly `PROG_CYCLES` clock cycles. A write that sets bit 0 without bit 1 starts nothing.
- R6: At commit, every staged latch `i` is written to array address `{row, i}`. `row` holds the upper address bits of the most recent staged write. Array bytes whose latch was not staged keep their previous value.
- R7: When a program cycle ends, the program bit and latch access clear, the option-select bit keeps its value, and all latches are emptied. A following sequence therefore re-writes none of the earlier bytes.
- R8: While the program bit is set, register writes and flash-area writes are ignored. In particular, latch access cannot be cleared during a program cycle.
- R9: A register write that clears latch access while the program bit is clear discards all staged bytes.
- R10: While option select is set, flash-area reads and staged writes use a separate two-byte option store addressed by `addr[0]`. A program cycle started in that state writes only the option store.
- R11: `bus_rdata` is loaded only in the cycle after a read strobe and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W+1 | Address; top bit selects the control register, the lower bits address the flash area |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 8 | Registered read data, valid the cycle after `bus_rd` |
| prog_busy | output | 1 | High for the duration of a program cycle |

## Verification
The bench targets the following cases:
- **Row moves mid-sequence.** The row address moves between writes inside one sequence. A design that kept the first row instead of the last would commit to the wrong row.
- **Second sequence.** A sequence follows another one that staged different latch positions. Latches that were not emptied would rewrite stale bytes in the new row.
- **Writes during a program cycle.** Register and flash writes are issued while programming is under way. If these were accepted, latch access would drop early or a new byte would slip into the commit.
- **Discard and option store.** It checks that software clearing of latch access throws away staged data, that the option store is isolated from the main array, and that the busy window is exactly `PROG_CYCLES` long.

// File: rtl/flwl_pkg.sv
// Shared constants and types of the flash row-latch controller.
// Assumes a byte-wide array and a fixed bank of sixteen staging latches.
package flwl_pkg;
    localparam int LATCH_N   = 16;
    localparam int LIDX_W    = $clog2(LATCH_N);
    localparam int OPT_BYTES = 2;
    localparam logic [7:0] ERASED = 8'hFF;

    // control bits as seen in bits 2..0 of the register
    typedef struct packed {
        logic opt;
        logic lat;
        logic pgm;
    } csr_t;
endpackage

// File: rtl/flwl_csr.sv
// Control register of the row-latch controller.
// Holds option select, latch access and program bits; accepts software
// writes only while idle; hardware clears program and latch access at
// the end of a program cycle. Assumes done only occurs while pgm is set.
module flwl_csr
    import flwl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_csr,
    input  logic [2:0] wbits,
    input  logic       done,
    output csr_t       csr,
    output logic       start,
    output logic       discard
);
    logic accept;

    // software writes are only honoured while no program cycle runs
    always_comb begin
        accept  = wr_csr && !csr.pgm;
        start   = accept && wbits[1] && wbits[0];
        discard = accept && !wbits[1];
    end

    // register update: hardware end-of-cycle clear has priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csr <= '0;
        end else if (done) begin
            csr.pgm <= 1'b0;
            csr.lat <= 1'b0;
        end else if (accept) begin
            csr.opt <= wbits[2];
            csr.lat <= wbits[1];
            csr.pgm <= wbits[1] && wbits[0];
        end
    end
endmodule

// File: rtl/flwl_timer.sv
// Program cycle timer. Runs for PROG_CYCLES clock cycles after start and
// flags done in the last one. Assumes PROG_CYCLES >= 1 and no start while
// running (the register blocks it).
module flwl_timer #(
    parameter int PROG_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int CNT_W = $clog2(PROG_CYCLES + 1);

    logic [CNT_W-1:0] cnt;
    logic             run;

    // last cycle of the run
    assign done = run && (cnt == '0);

    // countdown from PROG_CYCLES-1 to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (start) begin
            run <= 1'b1;
            cnt <= CNT_W'(PROG_CYCLES - 1);
        end else if (run) begin
            if (cnt == '0) run <= 1'b0;
            else           cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/flwl_latch_bank.sv
// Sixteen byte staging latches with per-slot valid flags and the row
// address of the most recent staged write. Clear empties every slot.
module flwl_latch_bank
    import flwl_pkg::*;
#(
    parameter int ROW_W = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         lwr,
    input  logic [LIDX_W-1:0]            lidx,
    input  logic [7:0]                   wdata,
    input  logic [ROW_W-1:0]             row_in,
    input  logic                         clear,
    output logic [LATCH_N-1:0][7:0]      ldata,
    output logic [LATCH_N-1:0]           lvalid,
    output logic [ROW_W-1:0]             row
);
    // one slot per latch position
    for (genvar g = 0; g < LATCH_N; g++) begin : g_slot
        // stage byte when this slot is addressed, drop on clear
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lvalid[g] <= 1'b0;
                ldata[g]  <= '0;
            end else if (clear) begin
                lvalid[g] <= 1'b0;
            end else if (lwr && (lidx == LIDX_W'(g))) begin
                lvalid[g] <= 1'b1;
                ldata[g]  <= wdata;
            end
        end
    end

    // row follows the last staged write
    always_ff @(posedge clk) begin
        if (!rst_n)   row <= '0;
        else if (lwr) row <= row_in;
    end
endmodule

// File: rtl/flwl_array.sv
// Behavioural flash storage: main array of 2**ADDR_W bytes plus a
// two-byte option store. Commit writes staged latches into one row (or
// the option store). Reset models an erased part (all 0xFF).
module flwl_array
    import flwl_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       commit,
    input  logic                       commit_opt,
    input  logic [ADDR_W-LIDX_W-1:0]   row,
    input  logic [LATCH_N-1:0][7:0]    ldata,
    input  logic [LATCH_N-1:0]         lvalid,
    input  logic                       rd_opt,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [7:0]                 rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem  [DEPTH];
    logic [7:0] optm [OPT_BYTES];

    // combinational read of either store
    assign rd_data = rd_opt ? optm[rd_addr[0]] : mem[rd_addr];

    // erase on reset, row or option commit afterwards
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED;
            for (int k = 0; k < OPT_BYTES; k++) optm[k] <= ERASED;
        end else if (commit) begin
            if (commit_opt) begin
                for (int k = 0; k < OPT_BYTES; k++)
                    if (lvalid[k]) optm[k] <= ldata[k];
            end else begin
                for (int i = 0; i < LATCH_N; i++)
                    if (lvalid[i]) mem[{row, LIDX_W'(i)}] <= ldata[i];
            end
        end
    end
endmodule

// File: rtl/flash_wlatch_ctrl.sv
// Top of the flash row-latch controller. Decodes the bus into register
// and flash-area accesses, stages latch writes, runs the timed program
// cycle and registers read data. Assumes one-cycle strobes; the top
// address bit selects the control register.
module flash_wlatch_ctrl
    import flwl_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int PROG_CYCLES = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W:0]   bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [7:0]        bus_rdata,
    output logic              prog_busy
);
    localparam int ROW_W = ADDR_W - LIDX_W;

    csr_t                     csr;
    logic                     sel_csr, wr_csr, lwr, start, discard, done;
    logic [LIDX_W-1:0]        lidx;
    logic [LATCH_N-1:0][7:0]  ldata;
    logic [LATCH_N-1:0]       lvalid;
    logic [ROW_W-1:0]         row;
    logic [7:0]               arr_rdata;
    logic                     csr_lat, csr_opt;

    // bus decode and latch steering
    always_comb begin
        sel_csr = bus_addr[ADDR_W];
        wr_csr  = bus_wr && sel_csr;
        lwr     = bus_wr && !sel_csr && csr.lat && !csr.pgm;
        lidx    = csr.opt ? {{(LIDX_W-1){1'b0}}, bus_addr[0]}
                          : bus_addr[LIDX_W-1:0];
    end

    assign prog_busy = csr.pgm;
    assign csr_lat   = csr.lat;
    assign csr_opt   = csr.opt;

    flwl_csr u_csr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_csr  (wr_csr),
        .wbits   (bus_wdata[2:0]),
        .done    (done),
        .csr     (csr),
        .start   (start),
        .discard (discard)
    );

    flwl_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .done  (done)
    );

    flwl_latch_bank #(.ROW_W(ROW_W)) u_latches (
        .clk    (clk),
        .rst_n  (rst_n),
        .lwr    (lwr),
        .lidx   (lidx),
        .wdata  (bus_wdata),
        .row_in (bus_addr[ADDR_W-1:LIDX_W]),
        .clear  (done || discard),
        .ldata  (ldata),
        .lvalid (lvalid),
        .row    (row)
    );

    flwl_array #(.ADDR_W(ADDR_W)) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (done),
        .commit_opt (csr.opt),
        .row        (row),
        .ldata      (ldata),
        .lvalid     (lvalid),
        .rd_opt     (csr.opt),
        .rd_addr    (bus_addr[ADDR_W-1:0]),
        .rd_data    (arr_rdata)
    );

    // registered read data, loaded only on a read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= sel_csr ? {5'b0, csr} : arr_rdata;
    end
endmodule

// File: rtl/flash_wlatch_ctrl_chk.sv
// Assertion checker for flash_wlatch_ctrl, attached with bind below.
// Watches the bus, busy output and the control/latch state.
module flash_wlatch_ctrl_chk
    import flwl_pkg::*;
#(
    parameter int PROG_CYCLES = 20
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sel_csr,
    input logic [7:0]         bus_wdata,
    input logic               bus_wr,
    input logic               bus_rd,
    input logic [7:0]         bus_rdata,
    input logic               prog_busy,
    input logic               csr_lat,
    input logic               csr_opt,
    input logic [LATCH_N-1:0] lvalid
);
    localparam int CW = $clog2(PROG_CYCLES + 2) + 1;

    logic [CW-1:0] busy_len;

    // length of the current busy stretch
    always_ff @(posedge clk) begin
        if (!rst_n)         busy_len <= '0;
        else if (prog_busy) busy_len <= busy_len + 1'b1;
        else                busy_len <= '0;
    end

    // R2: reserved bits read back as zero
    p_hi_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && sel_csr) |=> (bus_rdata[7:3] == 5'd0));

    // R5: busy window is exactly PROG_CYCLES long
    p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prog_busy) |-> (busy_len == CW'(PROG_CYCLES)));

    // R5: a cycle starts only from a register write with bits 1 and 0 set
    p_start_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_busy) |-> $past(bus_wr && sel_csr && bus_wdata[1] && bus_wdata[0]));

    // R8: latch access stays on during a program cycle
    p_lat_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        prog_busy |-> csr_lat);

    // R8: option select frozen while programming
    p_opt_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_busy && $past(prog_busy)) |-> $stable(csr_opt));

    // R7: end of cycle clears latch access and empties latches
    p_end_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prog_busy) |-> (!csr_lat && (lvalid == '0)));

    // R9: no staged byte survives without latch access
    p_no_stale_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_lat |-> (lvalid == '0));
endmodule

bind flash_wlatch_ctrl flash_wlatch_ctrl_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_csr   (bus_addr[ADDR_W]),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .prog_busy (prog_busy),
    .csr_lat   (csr_lat),
    .csr_opt   (csr_opt),
    .lvalid    (lvalid)
);

// File: tb/flash_wlatch_ctrl_bench.sv
`timescale 1ns/1ps
// Self-checking bench: directed corner cases plus seeded random row
// sequences compared with a bench-side model of the array.
module flash_wlatch_ctrl_bench;
    localparam int ADDR_W = 8;
    localparam int P      = 20;
    localparam logic [8:0] CSR = 9'h100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic       prog_busy;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] ref_mem [256];
    logic [7:0] ref_opt [2];
    logic [7:0] ref_ld  [16];
    logic       ref_lv  [16];
    logic [3:0] ref_row;

    always #2 clk = ~clk;

    flash_wlatch_ctrl #(.ADDR_W(ADDR_W), .PROG_CYCLES(P)) u_flash_wlatch_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .prog_busy(prog_busy));

    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    task automatic wr(input logic [8:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    // expected array byte from the model
    function automatic logic [7:0] exp_byte(input logic [7:0] a, input logic opt);
        return opt ? ref_opt[a[0]] : ref_mem[a];
    endfunction

    task automatic lat_wr(input logic [7:0] a, input logic [7:0] d, input logic opt);
        logic [3:0] idx;
        wr({1'b0, a}, d);
        idx = opt ? {3'b0, a[0]} : a[3:0];
        ref_ld[idx] = d; ref_lv[idx] = 1'b1; ref_row = a[7:4];
    endtask

    task automatic model_commit(input logic opt);
        for (int i = 0; i < 16; i++) begin
            if (ref_lv[i]) begin
                if (opt) begin
                    if (i < 2) ref_opt[i] = ref_ld[i];
                end else begin
                    ref_mem[{ref_row, 4'(i)}] = ref_ld[i];
                end
            end
            ref_lv[i] = 1'b0;
        end
    endtask

    task automatic wait_idle();
        while (prog_busy) @(negedge clk);
    endtask

    // start, measure busy window, update model
    task automatic do_prog(input logic opt);
        int cnt;
        wr(CSR, {5'b0, opt, 2'b11});
        cnt = 0;
        while (prog_busy && cnt < 1000) begin cnt++; @(negedge clk); end
        chk("R5 busy length", cnt, P);
        model_commit(opt);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd5813));
        for (int i = 0; i < 256; i++) ref_mem[i] = 8'hFF;
        ref_opt[0] = 8'hFF; ref_opt[1] = 8'hFF;
        for (int i = 0; i < 16; i++) begin ref_ld[i] = '0; ref_lv[i] = 1'b0; end
        ref_row = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 busy", int'(prog_busy), 0);
        rd(CSR, v); chk("R1 csr", v, 8'h00);
        rd(9'h010, v); chk("R1 array", v, 8'hFF);

        // R2 reserved bits
        wr(CSR, 8'hF8); rd(CSR, v); chk("R2 reserved", v, 8'h00);

        // R3 write with latch access off
        wr(9'h020, 8'h5C); rd(9'h020, v); chk("R3 ignored", v, 8'hFF);

        // R4 staged byte not yet visible
        wr(CSR, 8'h02); lat_wr(8'h35, 8'hA5, 1'b0);
        rd(9'h035, v); chk("R4 before commit", v, 8'hFF);
        rd(CSR, v); chk("R4 csr lat", v, 8'h02);
        do_prog(1'b0);
        rd(9'h035, v); chk("R5 committed", v, 8'hA5);
        rd(CSR, v); chk("R7 csr cleared", v, 8'h00);

        // R5 program bit without latch access
        wr(CSR, 8'h01); rd(CSR, v); chk("R5 no start csr", v, 8'h00);
        chk("R5 no start busy", int'(prog_busy), 0);

        // R6 last row wins, unstaged bytes untouched
        wr(CSR, 8'h02); lat_wr(8'h41, 8'h11, 1'b0); lat_wr(8'h72, 8'h22, 1'b0);
        do_prog(1'b0);
        rd(9'h071, v); chk("R6 row B idx1", v, 8'h11);
        rd(9'h072, v); chk("R6 row B idx2", v, 8'h22);
        rd(9'h041, v); chk("R6 row A untouched", v, 8'hFF);
        rd(9'h070, v); chk("R6 unstaged", v, 8'hFF);

        // R7 latches emptied between sequences
        wr(CSR, 8'h02); lat_wr(8'h93, 8'h33, 1'b0); do_prog(1'b0);
        rd(9'h091, v); chk("R7 stale latch", v, 8'hFF);
        rd(9'h093, v); chk("R7 new byte", v, 8'h33);

        // R8 writes during a program cycle
        wr(CSR, 8'h02); lat_wr(8'hA3, 8'h3C, 1'b0);
        wr(CSR, 8'h03);
        wr(CSR, 8'h00);
        wr(9'h0A4, 8'h99);
        rd(CSR, v); chk("R8 csr held", v, 8'h03);
        wait_idle(); model_commit(1'b0);
        rd(9'h0A3, v); chk("R8 commit kept", v, 8'h3C);
        rd(9'h0A4, v); chk("R8 busy write ignored", v, 8'hFF);

        // R9 software clear discards staged data
        wr(CSR, 8'h02); lat_wr(8'h55, 8'h77, 1'b0);
        wr(CSR, 8'h00);
        for (int i = 0; i < 16; i++) ref_lv[i] = 1'b0;
        wr(CSR, 8'h02); lat_wr(8'h56, 8'h12, 1'b0); do_prog(1'b0);
        rd(9'h055, v); chk("R9 discarded", v, 8'hFF);
        rd(9'h056, v); chk("R9 later byte", v, 8'h12);

        // R10 option store
        wr(CSR, 8'h06); lat_wr(8'h01, 8'h5A, 1'b1); do_prog(1'b1);
        rd(CSR, v); chk("R7 opt kept", v, 8'h04);
        rd(9'h001, v); chk("R10 opt byte1", v, 8'h5A);
        rd(9'h000, v); chk("R10 opt byte0", v, 8'hFF);
        wr(CSR, 8'h00);
        rd(9'h001, v); chk("R10 main isolated", v, exp_byte(8'h01, 1'b0));

        // R11 read data holds without strobe
        rd(CSR, v);
        wr(CSR, 8'h02);
        @(negedge clk); chk("R11 hold", bus_rdata, 8'h00);
        rd(CSR, v); chk("R11 reload", v, 8'h02);
        wr(CSR, 8'h00);

        // random row sequences with mid-sequence row moves (R4 R6 R7)
        for (int r = 0; r < 30; r++) begin
            logic [3:0] ra, rb;
            int n;
            ra = 4'($urandom); rb = 4'($urandom);
            n = 1 + int'($urandom % 12);
            wr(CSR, 8'h02);
            for (int k = 0; k < n; k++) begin
                logic [3:0] row;
                row = (k < n / 2) ? ra : rb;
                lat_wr({row, 4'($urandom)}, 8'($urandom), 1'b0);
            end
            do_prog(1'b0);
            for (int i = 0; i < 16; i++) begin
                rd({1'b0, rb, 4'(i)}, v);
                chk("R6 random row", v, exp_byte({rb, 4'(i)}, 1'b0));
            end
        end
        summary();
    end
endmodule